// File: doc/BRIEF.md
# I2C Register-File Target with Strap-Selected Address

This block answers as a target on a two-wire open-drain serial bus and gives the bus controller access to a small register file that lives in user logic. Its 7-bit bus address is a 4-bit device identifier set by a parameter (default `0100`) followed by three strap inputs, so up to eight copies can share one bus. Both bus lines are sampled through two-flop synchronizers on the system clock, and edges, start conditions and stop conditions are derived from the synchronized copies. The block pulls SDA low through an output enable. It can also pull SCL low when the user logic says it is not ready.

A write transaction carries the address byte with the direction bit at 0. The first data byte loads an internal register pointer. Each later byte produces a one-cycle write strobe at the pointer, and the pointer then advances. A read transaction carries the direction bit at 1. It returns register contents from the current pointer and advances after every byte. The pointer wraps from the last register back to register 0. If the address does not match, the block stays silent until the next start condition.

The controller is an eight-state machine plus a hold state. The states are IDLE, ADDR, ADDR_ACK, WR_BYTE, WR_ACK, RD_BYTE, RD_ACK, HOLD and IGNORE. A start condition moves any state to ADDR, and a stop condition moves any state to IDLE. From ADDR, the falling SCL edge after the eighth bit goes to ADDR_ACK on a match and to IGNORE otherwise. WR_BYTE goes to WR_ACK and RD_BYTE goes to RD_ACK, each on the falling edge after eight bits. When an acknowledge slot ends (a falling SCL edge in ADDR_ACK, WR_ACK or RD_ACK), the machine goes to HOLD if the user logic is not ready. Otherwise it goes to RD_BYTE or WR_BYTE, depending on the direction bit. RD_ACK goes to IGNORE instead if the controller did not acknowledge. HOLD goes to RD_BYTE or WR_BYTE once the user logic is ready.

Top module: `i2c_strap_target`

## Requirements
- R1: The address byte is matched when bits 7..4 equal the identifier `0100` and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects the direction (0 = write, 1 = read), so with all straps at 0 the write byte is 0x40 and the read byte is 0x41.
- R2: After a matching address byte or an accepted write data byte, SDA is held low for the whole ninth SCL clock and is released after that clock's falling edge.
- R3: On an address mismatch, SDA stays released for the acknowledge slot, and the block neither drives SDA nor strobes a write until the next start, even if a later byte happens to equal its own address.
- R4: In a write transaction, the first data byte loads the register pointer from its low `PTR_W` bits, without a write strobe.
- R5: Each later write byte gives `rf_we` high for exactly one cycle, with `rf_addr` equal to the pointer and `rf_wdata` equal to the byte. The pointer then increments and wraps from 2^PTR_W-1 to 0.
- R6: In a read transaction, the block sends `rf_rdata` for the current pointer, MSB first. After each byte the pointer increments with the same wrap.
- R7: After a read byte that the controller does not acknowledge (SDA high in the ninth clock), the block releases SDA and stays released until a start or stop.
- R8: A start (SDA falling while SCL is high) restarts address framing from any state. A stop (SDA rising while SCL is high) returns to idle and discards a partial byte without writing it.
- R9: SDA from the block changes only while the synchronized SCL is low, so it is stable throughout each SCL high phase.
- R10: If `host_ready` is low when an acknowledge slot ends, `bus_scl_oe` is asserted (SCL held low) until `host_ready` is high. It is released in the clock after that.
- R11: During and right after reset, `bus_sda_oe`, `bus_scl_oe` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_scl_i | input | 1 | Sampled SCL line level |
| bus_sda_i | input | 1 | Sampled SDA line level |
| strap_i | input | 3 | Address strap pins (address bits 2..0) |
| host_ready | input | 1 | User logic ready for the next byte; low stretches SCL |
| bus_scl_oe | output | 1 | 1 pulls SCL low |
| bus_sda_oe | output | 1 | 1 pulls SDA low |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_addr | output | PTR_W | Register pointer (write and read address) |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data for `rf_addr` |

## Verification
Each response of the block to an SCL falling edge is due two or three system clocks after that edge on the bus: two synchronizer flops plus one register. This applies to an acknowledge pull-down, a transmitted bit, the write strobe and the stretch enable. The bench controller therefore keeps SCL low for 20 clocks before it releases it, and samples SDA at a quarter and at three quarters of the high phase. Both samples must agree. Write strobes are compared at falling clock edges against a queue filled when each byte is sent. Stretch is checked 20 clocks after the acknowledge slot ends, again after a further 40 clocks, and 3 clocks after `host_ready` rises.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HOLD,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;          // idle bus reads high
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    // SDA edge while SCL stays high on both samples
    assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2ct_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'b0100,
    parameter int         PTR_W       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_scl_i,
    input  logic              bus_sda_i,
    input  logic [2:0]        strap_i,
    input  logic              host_ready,
    output logic              bus_scl_oe,
    output logic              bus_sda_oe,
    output logic              rf_we,
    output logic [PTR_W-1:0]  rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    input  logic [BYTE_W-1:0] rf_rdata
);
    localparam int               CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);

    // ---------------- front end ----------------
    logic [1:0] raw_lines, sync_lines;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {bus_scl_i, bus_sda_i};

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (sync_lines)
    );
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    i2ct_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // ---------------- state and datapath ----------------
    tgt_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              rd_mode, first_byte, ctl_nack;
    logic              byte_done, addr_hit, load_tx, ack_slot;

    assign byte_done = (bit_cnt == FULL);
    assign addr_hit  = (shreg[BYTE_W-1:1] == {DEV_ID, strap_i});
    assign ack_slot  = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
    assign load_tx   = (state_nx == ST_RD_BYTE) && (state != ST_RD_BYTE);

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR:
                    if (scl_fall && byte_done)
                        state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK, ST_WR_ACK:
                    if (scl_fall)
                        state_nx = !host_ready ? ST_HOLD
                                 : (rd_mode ? ST_RD_BYTE : ST_WR_BYTE);
                ST_RD_ACK:
                    if (scl_fall)
                        state_nx = ctl_nack    ? ST_IGNORE
                                 : !host_ready ? ST_HOLD : ST_RD_BYTE;
                ST_HOLD:
                    if (host_ready)
                        state_nx = rd_mode ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (scl_fall && byte_done) state_nx = ST_WR_ACK;
                ST_RD_BYTE:
                    if (scl_fall && byte_done) state_nx = ST_RD_ACK;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            ptr        <= '0;
            rd_mode    <= 1'b0;
            first_byte <= 1'b1;
            ctl_nack   <= 1'b0;
            bus_sda_oe <= 1'b0;
            bus_scl_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt    <= '0;
            first_byte <= 1'b1;
            bus_sda_oe <= 1'b0;
            bus_scl_oe <= 1'b0;
        end else begin
            if (scl_rise && (state == ST_ADDR || state == ST_WR_BYTE || state == ST_RD_BYTE))
                bit_cnt <= bit_cnt + 1'b1;
            if (scl_rise && (state == ST_ADDR || state == ST_WR_BYTE))
                shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (scl_rise && state == ST_RD_ACK)
                ctl_nack <= sda_s;

            if (scl_fall && byte_done && state == ST_ADDR && addr_hit) begin
                bus_sda_oe <= 1'b1;
                rd_mode    <= shreg[0];
            end

            if (scl_fall && byte_done && state == ST_WR_BYTE) begin
                bus_sda_oe <= 1'b1;
                if (first_byte) begin
                    ptr        <= shreg[PTR_W-1:0];
                    first_byte <= 1'b0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end

            if (scl_fall && state == ST_RD_BYTE) begin
                if (byte_done) begin
                    bus_sda_oe <= 1'b0;
                    ptr        <= ptr + 1'b1;
                end else begin
                    bus_sda_oe <= ~shreg[BYTE_W-2];
                    shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                end
            end

            if (scl_fall && (ack_slot || state == ST_RD_ACK)) begin
                bus_sda_oe <= 1'b0;
                bit_cnt    <= '0;
                bus_scl_oe <= (state_nx == ST_HOLD);
            end

            if (state == ST_HOLD && host_ready)
                bus_scl_oe <= 1'b0;

            if (load_tx) begin
                shreg      <= rf_rdata;
                bus_sda_oe <= ~rf_rdata[BYTE_W-1];
            end
        end
    end

    assign rf_we    = (state == ST_WR_BYTE) && scl_fall && byte_done && !first_byte;
    assign rf_addr  = ptr;
    assign rf_wdata = shreg;

    // ---------------- assertions ----------------
    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sda_oe != $past(bus_sda_oe)) |-> !scl_s);                        // R9
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> (!bus_sda_oe && !rf_we)); // R3
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);                                                    // R5
    AST_HOLD_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_scl_oe) |-> !scl_s);                                        // R10
    AST_START_REFRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));                   // R8
endmodule

// File: tb/sim_i2c_strap_target.sv
`timescale 1ns/1ps
module sim_i2c_strap_target;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       host_ready = 1'b1;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe, rf_we;
    logic [2:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic [7:0] mem [8];
    logic [7:0] exp_mem [8];
    logic [2:0] bptr = '0;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    typedef struct packed { logic [2:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    always #10 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);
    assign rf_rdata = mem[rf_addr];

    i2c_strap_target u0 (
        .clk(clk), .rst_n(rst_n), .bus_scl_i(scl_line), .bus_sda_i(sda_line),
        .strap_i(strap), .host_ready(host_ready), .bus_scl_oe(scl_oe),
        .bus_sda_oe(sda_oe), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, want);
        end
    endtask

    // monitor: pops expected writes as strobes appear
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 R4 R8 unexpected write strobe", {21'd0, rf_addr, rf_wdata}, 0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(rf_addr == e.a && rf_wdata == e.d, "R5 write addr/data",
                    {21'd0, rf_addr, rf_wdata}, {21'd0, e.a, e.d});
            end
        end
    end

    task automatic clk_high(output logic s0, output logic s1);
        m_scl_low = 1'b0;
        while (!scl_line) tick(1);
        tick(H/4); s0 = sda_line;
        tick(H/2); s1 = sda_line;
        tick(H/4);
        m_scl_low = 1'b1;
        tick(H);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; tick(H/2);
        m_scl_low = 1'b0; tick(H);
        bus_start();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(H/2);
        m_scl_low = 1'b0; tick(H);
        m_sda_low = 1'b0; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s0, s1;
        for (int i = 7; i > 7 - n; i--) begin
            m_sda_low = !b[i]; tick(H/2);
            clk_high(s0, s1);
        end
    endtask

    // send a byte and check the ninth-clock response
    task automatic put(input logic [7:0] b, input bit want_ack, input string tag);
        logic s0, s1;
        send_bits(b, 8);
        m_sda_low = 1'b0; tick(H/2);
        clk_high(s0, s1);
        chk(((!s0 && !s1) == want_ack) && (s0 == s1), tag, {s0, s1}, want_ack ? 2'b00 : 2'b11);
    endtask

    task automatic set_ptr(input logic [2:0] p);
        put({5'd0, p}, 1'b1, "R4 pointer byte acked");
        bptr = p;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        exp_q.push_back({bptr, d});
        exp_mem[bptr] = d;
        bptr = bptr + 1'b1;
        put(d, 1'b1, "R2 R5 data byte acked");
    endtask

    task automatic rd_byte(input bit give_ack);
        logic s0, s1;
        logic [7:0] d;
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(H/2);
            clk_high(s0, s1);
            d[i] = s0;
            chk(s0 == s1, "R9 SDA stable while SCL high", {31'd0, s1}, {31'd0, s0});
        end
        chk(d == exp_mem[bptr], "R6 read data", d, exp_mem[bptr]);
        bptr = bptr + 1'b1;
        m_sda_low = give_ack; tick(H/2);
        clk_high(s0, s1);
    endtask

    initial begin
        // R11: reset state
        tick(5);
        chk(!sda_oe && !scl_oe && !rf_we, "R11 outputs in reset", {sda_oe, scl_oe, rf_we}, 0);
        rst_n = 1'b1;
        tick(5);
        chk(!sda_oe && !scl_oe && !rf_we, "R11 outputs after reset", {sda_oe, scl_oe, rf_we}, 0);

        // R1 R4 R5: write with straps 000
        bus_start();
        put(8'h40, 1'b1, "R1 R2 write address 0x40 acked");
        set_ptr(3'd2);
        wr_byte(8'hA5);
        wr_byte(8'h3C);
        tick(5);
        chk(!sda_oe, "R2 SDA released after ack clock", sda_oe, 0);
        bus_stop();

        // R6 R7: read back through a repeated start
        bus_start();
        put(8'h40, 1'b1, "R1 write address acked");
        set_ptr(3'd2);
        bus_rstart();
        put(8'h41, 1'b1, "R1 read address 0x41 acked");
        rd_byte(1'b1);
        rd_byte(1'b0);
        tick(5);
        chk(!sda_oe, "R7 released after controller NACK", sda_oe, 0);
        send_bits(8'h00, 2);
        chk(!sda_oe, "R7 still released until stop", sda_oe, 0);
        bus_stop();

        // R5 R6: pointer wrap
        bus_start();
        put(8'h40, 1'b1, "R1 address acked");
        set_ptr(3'd7);
        wr_byte(8'h11);
        wr_byte(8'h22);
        bus_rstart();
        put(8'h40, 1'b1, "R1 address acked");
        set_ptr(3'd7);
        bus_rstart();
        put(8'h41, 1'b1, "R1 read address acked");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop();

        // R3: mismatch with straps 101, then R1 match on 0x4A
        strap = 3'b101;
        tick(10);
        bus_start();
        put(8'h40, 1'b0, "R3 mismatched address not acked");
        put(8'h4A, 1'b0, "R3 own address mid-transaction ignored");
        put(8'h55, 1'b0, "R3 data ignored after mismatch");
        bus_stop();
        bus_start();
        put(8'h4A, 1'b1, "R1 strap address 0x4A acked");
        set_ptr(3'd0);
        // R8: partial byte then stop, no write
        send_bits(8'hFF, 4);
        bus_stop();
        bus_start();
        put(8'h4B, 1'b1, "R1 R8 read after aborted byte");
        rd_byte(1'b0);
        bus_stop();

        // R10: clock stretch at end of address acknowledge
        host_ready = 1'b0;
        bus_start();
        put(8'h4A, 1'b1, "R1 address acked before stretch");
        chk(scl_oe && !scl_line, "R10 SCL held while not ready", {scl_oe, scl_line}, 2'b10);
        tick(40);
        chk(scl_oe && !scl_line, "R10 SCL still held", {scl_oe, scl_line}, 2'b10);
        host_ready = 1'b1;
        tick(3);
        chk(!scl_oe, "R10 SCL released when ready", scl_oe, 0);
        set_ptr(3'd1);
        wr_byte(8'h77);
        bus_stop();

        tick(20);
        chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule